// File: doc/BRIEF.md
# Masked-Byte CRC Wake-Frame Matcher

This block looks at the bytes of a received Ethernet frame as they arrive on a byte-wide stream. The stream carries a data byte together with a valid strobe, a start-of-frame strobe and an end-of-frame strobe. The block considers only the opening 64 bytes of each frame. A programmable 64-bit byte mask decides which of those bytes are fed into an IEEE 802.3 CRC-32. The bytes the mask leaves out do not touch the running CRC.

The comparison happens once per frame. It takes place as soon as the 64th byte has been consumed, or at end-of-frame if the frame is shorter. At that point the inverted CRC is compared with a programmed 32-bit signature. If the two are equal, the block raises a single-cycle match pulse, which a power-management controller can use as a wake-up event.

The mask and the signature sit in six 16-bit read/write words behind a simple register port.

Top module: `wake_crc_matcher`

## Requirements
- R1: Word address 0..3 holds mask word k, address 4 holds signature bits 15:0 and address 5 holds signature bits 31:16. All six words reset to 0 and read back what was last written on `cfg_rdata` (combinational on `cfg_addr`). Addresses 6 and 7 read 0.
- R2: Mask word k, bit n selects frame byte 16k+n+1. Byte 1 is the byte accepted together with `rx_sof`. For example, word 1 bit 0 is byte 17 and word 3 bit 15 is byte 64.
- R3: The CRC uses the reflected polynomial 0xEDB88320 and starts from 0xFFFFFFFF. Each byte is folded in LSB first. The bitwise inverse of the result is compared with {word 5, word 4}. A nine-byte ASCII "123456789" pattern gives 0xCBF43926.
- R4: A byte whose mask bit is 0 leaves the CRC state unchanged.
- R5: Every byte accepted with `rx_sof` restarts the CRC and the byte count, even if a frame is still open.
- R6: The compare takes place once per frame, at byte 64 or at the byte carrying `rx_eof`, whichever comes first. Bytes after byte 64 are ignored until the next `rx_sof`.
- R7: `wake_match` is high for exactly the one cycle after the clock edge that accepts the closing byte, and only when the compare is equal.
- R8: While all 64 mask bits are 0, `wake_match` never asserts.
- R9: In a frame shorter than 64 bytes, the mask bits of bytes that never arrive have no effect. The compare uses the CRC gathered up to end-of-frame.
- R10: Cycles with `rx_valid` low are ignored. Bytes with `rx_valid` high that arrive outside a frame are also ignored: before any `rx_sof`, or after the compare and before the next `rx_sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| rx_valid | input | 1 | Stream byte valid |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Stream byte |
| wake_match | output | 1 | One-cycle pattern match pulse |

## Verification
The case hardest to reach from the ports is the cut-off at byte 64. Reaching it needs a frame longer than the window, a mask whose only selected byte is the last one in the window (word 3 bit 15), and trailing bytes that must not produce a second compare. The bench sends a 70-byte frame with exactly that mask. It also restarts a frame mid-stream with a fresh start-of-frame, and inserts gaps and stray bytes outside a frame. Every cycle is compared against a behavioural model, and the model's CRC is tied to the known "123456789" check value.

// File: rtl/wcm_pkg.sv
package wcm_pkg;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam int unsigned CFG_DW   = 16;

  // Fold one byte into a reflected CRC-32 register, LSB first.
  function automatic logic [31:0] crc32_fold_byte(input logic [31:0] state,
                                                  input logic [7:0]  data);
    logic [31:0] acc;
    acc = state;
    for (int b = 0; b < 8; b++) begin
      if (acc[0] ^ data[b]) acc = (acc >> 1) ^ CRC_POLY;
      else                  acc = acc >> 1;
    end
    return acc;
  endfunction
endpackage

// File: rtl/wcm_regs.sv
module wcm_regs #(
  parameter int unsigned MASK_WORDS = 4,
  parameter int unsigned ADDR_W     = 3,
  localparam int unsigned NWORDS    = MASK_WORDS + 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [wcm_pkg::CFG_DW-1:0]     wdata,
  output logic [wcm_pkg::CFG_DW-1:0]     rdata,
  output logic [MASK_WORDS*16-1:0]       mask_bits,
  output logic [31:0]                    expect_crc
);
  logic [wcm_pkg::CFG_DW-1:0] word_q [NWORDS];

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             word_q[i] <= '0;
      else if (wr && addr == ADDR_W'(i))      word_q[i] <= wdata;
    end
  end

  for (genvar k = 0; k < MASK_WORDS; k++) begin : g_mask
    assign mask_bits[16*k +: 16] = word_q[k];
  end

  assign expect_crc = {word_q[MASK_WORDS+1], word_q[MASK_WORDS]};

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (addr == ADDR_W'(i)) rdata = word_q[i];
    end
  end
endmodule

// File: rtl/wcm_window.sv
module wcm_window #(
  parameter int unsigned WIN_BYTES = 64,
  localparam int unsigned IDX_W    = $clog2(WIN_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             take,
  output logic             start,
  output logic             last,
  output logic [IDX_W-1:0] pos,
  output logic             active
);
  logic [IDX_W-1:0] next_q;
  logic             active_q;

  assign start  = in_valid & in_sof;
  assign take   = in_valid & (in_sof | active_q);
  assign pos    = in_sof ? '0 : next_q;
  assign last   = take & (in_eof | (pos == IDX_W'(WIN_BYTES - 1)));
  assign active = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      next_q   <= '0;
    end else if (take) begin
      active_q <= !last;
      next_q   <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/wcm_crc.sv
module wcm_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        start,
  input  logic        sel,
  input  logic [7:0]  data,
  output logic [31:0] crc_q,
  output logic [31:0] crc_nxt
);
  logic [31:0] crc_base;

  assign crc_base = start ? wcm_pkg::CRC_INIT : crc_q;
  assign crc_nxt  = sel ? wcm_pkg::crc32_fold_byte(crc_base, data) : crc_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= wcm_pkg::CRC_INIT;
    else if (take) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/wake_crc_matcher.sv
module wake_crc_matcher #(
  parameter int unsigned WIN_BYTES  = 64,
  parameter int unsigned ADDR_W     = 3,
  localparam int unsigned MASK_WORDS = WIN_BYTES / 16,
  localparam int unsigned IDX_W      = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  output logic              wake_match
);
  logic [MASK_WORDS*16-1:0] mask_bits;
  logic [31:0]              expect_crc;
  logic                     take_w, start_w, last_w, active_w, sel_w;
  logic [IDX_W-1:0]         pos_w;
  logic [31:0]              crc_q, crc_nxt;
  logic                     mask_nz, hit_w, match_q;

  wcm_regs #(.MASK_WORDS(MASK_WORDS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .mask_bits(mask_bits), .expect_crc(expect_crc)
  );

  wcm_window #(.WIN_BYTES(WIN_BYTES)) u_win (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_sof(rx_sof), .in_eof(rx_eof),
    .take(take_w), .start(start_w), .last(last_w), .pos(pos_w), .active(active_w)
  );

  assign sel_w = take_w & mask_bits[pos_w];

  wcm_crc u_crc (
    .clk(clk), .rst_n(rst_n), .take(take_w), .start(start_w), .sel(sel_w),
    .data(rx_data), .crc_q(crc_q), .crc_nxt(crc_nxt)
  );

  assign mask_nz = |mask_bits;
  assign hit_w   = last_w & mask_nz & ((~crc_nxt) == expect_crc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= hit_w;
  end

  assign wake_match = match_q;
endmodule

// File: rtl/wcm_checker.sv
module wcm_checker #(
  parameter int unsigned MASK_WORDS = 4,
  parameter int unsigned ADDR_W     = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     take,
  input logic                     start,
  input logic                     sel,
  input logic                     last,
  input logic                     active,
  input logic [31:0]              crc_q,
  input logic [MASK_WORDS*16-1:0] mask_bits,
  input logic                     match,
  input logic                     wr,
  input logic [ADDR_W-1:0]        addr,
  input logic [15:0]              wdata
);
  // R4: a skipped byte in an open frame keeps the CRC
  a_r4_skip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    take && !start && !sel |=> crc_q == $past(crc_q));

  // R5: an unselected first byte leaves the CRC at its seed
  a_r5_start_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    take && start && !sel |=> crc_q == 32'hFFFF_FFFF);

  // R10: no accepted byte, no CRC change
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> crc_q == $past(crc_q));

  // R6: the window closes after the compare
  a_r6_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !active);

  // R7: a pulse follows a closing byte
  a_r7_pulse_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(last));

  // R8: empty mask never matches
  a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(mask_bits != '0));

  for (genvar k = 0; k < MASK_WORDS; k++) begin : g_wr
    // R1: a write lands in its mask word
    a_r1_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr && addr == ADDR_W'(k) |=> mask_bits[16*k +: 16] == $past(wdata));
  end
endmodule

bind wake_crc_matcher wcm_checker #(.MASK_WORDS(MASK_WORDS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take_w), .start(start_w), .sel(sel_w),
  .last(last_w), .active(active_w), .crc_q(crc_q), .mask_bits(mask_bits),
  .match(wake_match), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata)
);

// File: tb/wake_crc_matcher_test.sv
module wake_crc_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        wake_match;

  int n_tests = 0, n_fail = 0, hits = 0;

  always #5 clk = ~clk;

  wake_crc_matcher uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data), .wake_match(wake_match)
  );

  // Forward (non-reflected) CRC-32 on the bit-reversed register
  function automatic logic [31:0] fwd_step(input logic [31:0] s, input logic [7:0] b);
    logic [31:0] r = s;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[31] ^ b[i];
      r = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C1_1DB7;
    end
    return r;
  endfunction

  function automatic logic [31:0] finish_crc(input logic [31:0] s);
    logic [31:0] o;
    for (int i = 0; i < 32; i++) o[i] = s[31-i];
    return ~o;
  endfunction

  function automatic logic [31:0] sig_of(input logic [7:0] q[$], input logic [63:0] m);
    logic [31:0] s = 32'hFFFF_FFFF;
    for (int i = 0; i < q.size() && i < 64; i++)
      if (m[i]) s = fwd_step(s, q[i]);
    return finish_crc(s);
  endfunction

  // Behavioural reference model, updated on every rising edge
  logic [15:0] m_reg [6];
  logic        m_open = 1'b0, m_pulse = 1'b0;
  int          m_idx = 0;
  logic [31:0] m_state = 32'hFFFF_FFFF;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = '0;
      m_open = 1'b0; m_pulse = 1'b0; m_idx = 0;
    end else begin
      logic [63:0] mk;
      mk = {m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
      m_pulse = 1'b0;
      if (rx_valid && (rx_sof || m_open)) begin
        if (rx_sof) begin m_idx = 0; m_state = 32'hFFFF_FFFF; end
        if (mk[m_idx]) m_state = fwd_step(m_state, rx_data);
        if (rx_eof || m_idx == 63) begin
          m_open = 1'b0;
          m_pulse = (mk != 0) && (finish_crc(m_state) == {m_reg[5], m_reg[4]});
        end else begin
          m_open = 1'b1;
          m_idx++;
        end
      end
      if (cfg_wr && cfg_addr < 6) m_reg[cfg_addr] = cfg_wdata;
    end
  end

  // Per-cycle comparison against the model (R7 timing and value)
  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (wake_match !== m_pulse) begin
        n_fail++;
        $display("FAIL R7 cycle model: wake_match=%0b expected=%0b at %0t", wake_match, m_pulse, $time);
      end
      if (wake_match) hits++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic set_mask(input logic [63:0] m);
    for (int k = 0; k < 4; k++) wr(3'(k), m[16*k +: 16]);
  endtask

  task automatic set_sig(input logic [31:0] s);
    wr(3'd4, s[15:0]); wr(3'd5, s[31:16]);
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
    @(negedge clk); cfg_addr = a; #1;
    check(req, {16'h0, cfg_rdata}, {16'h0, exp});
  endtask

  task automatic send(input logic [7:0] q[$], input bit with_eof, input bit gaps);
    for (int i = 0; i < q.size(); i++) begin
      if (gaps && i % 3 == 1) begin
        @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'hEE;
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = with_eof && (i == q.size() - 1);
      rx_data = q[i];
    end
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic stray(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'(i * 37);
    end
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] ascii[$];
    logic [7:0] f[$];
    int h0;
    ascii = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 6; a++) rd("R1 reset value", 3'(a), 16'h0);
    check("R7 no pulse at reset", {31'h0, wake_match}, 32'h0);

    // R1: readback and unused addresses
    for (int a = 0; a < 6; a++) wr(3'(a), 16'hA5C0 + 16'(a));
    for (int a = 0; a < 6; a++) rd("R1 readback", 3'(a), 16'hA5C0 + 16'(a));
    rd("R1 address 6 reads zero", 3'd6, 16'h0);
    rd("R1 address 7 reads zero", 3'd7, 16'h0);

    // R3 bench function against the known check value
    check("R3 check value", sig_of(ascii, 64'h1FF), 32'hCBF4_3926);

    // R8: empty mask, signature of an empty selection
    set_mask(64'h0); set_sig(32'h0);
    h0 = hits; send(ascii, 1, 0); settle();
    check("R8 empty mask no match", hits - h0, 0);

    // R3: nine ASCII bytes
    set_mask(64'h1FF); set_sig(32'hCBF4_3926);
    h0 = hits; send(ascii, 1, 0); settle();
    check("R3 ascii pattern matches", hits - h0, 1);

    // R7: wrong signature gives no pulse
    set_sig(32'hCBF4_3927);
    h0 = hits; send(ascii, 1, 0); settle();
    check("R7 mismatch no pulse", hits - h0, 0);

    // R2/R4: pattern at bytes 17..25, junk elsewhere
    f = {};
    for (int i = 0; i < 40; i++) f.push_back(8'(i * 91 + 5));
    for (int i = 0; i < 9; i++) f[16 + i] = ascii[i];
    set_mask(64'h1FF << 16); set_sig(32'hCBF4_3926);
    h0 = hits; send(f, 1, 0); settle();
    check("R2 R4 offset pattern matches", hits - h0, 1);
    f[3] = 8'h00; f[30] = 8'hFF;
    h0 = hits; send(f, 1, 0); settle();
    check("R4 unselected bytes ignored", hits - h0, 1);

    // R6/R2: only byte 64 selected, frame of 70 bytes
    f = {};
    for (int i = 0; i < 70; i++) f.push_back(8'(i * 13 + 1));
    set_mask(64'h8000_0000_0000_0000);
    set_sig(sig_of(f, 64'h8000_0000_0000_0000));
    h0 = hits; send(f, 1, 0); settle();
    check("R6 compare at byte 64 single pulse", hits - h0, 1);
    h0 = hits; send(f, 0, 0); settle();
    check("R6 window closes without eof", hits - h0, 1);

    // R9: all mask bits set, short frame
    set_mask(64'hFFFF_FFFF_FFFF_FFFF); set_sig(32'hCBF4_3926);
    h0 = hits; send(ascii, 1, 0); settle();
    check("R9 short frame ignores missing bytes", hits - h0, 1);

    // R5: restart mid-frame
    set_mask(64'h1FF);
    h0 = hits;
    f = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    send(f, 0, 0); send(ascii, 1, 0); settle();
    check("R5 sof restarts frame", hits - h0, 1);

    // R10: stray bytes and gaps
    h0 = hits; stray(12); send(ascii, 1, 1); stray(5); settle();
    check("R10 stray and gaps ignored", hits - h0, 1);

    // Random frames, checked each cycle by the model
    for (int t = 0; t < 40; t++) begin
      logic [63:0] m;
      int len;
      len = 1 + ($urandom % 90);
      f = {};
      for (int i = 0; i < len; i++) f.push_back(8'($urandom));
      m = (t % 7 == 0) ? 64'h0 : {$urandom, $urandom};
      set_mask(m);
      set_sig((t % 2 == 0) ? sig_of(f, m) : $urandom);
      send(f, ($urandom % 4) != 0, t % 3 == 0);
      if (t % 5 == 0) stray(3);
      settle();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule